// File: doc/BRIEF.md
# BCD Time-of-Day Counter Chain

This block is the counting core of a 24-hour digital clock. A free-running prescaler divides the 32768 Hz input clock down to one tick per second. A chain of six binary-coded decimal digit counters holds seconds, minutes and hours. Every register sits in the one input clock domain. Each digit advances on a single-cycle enable, and that enable is raised only when every digit below it is wrapping back to zero in the same cycle. No digit is clocked by the output of another digit.

Both the seconds pair and the minutes pair are a mod-10 units digit followed by a mod-6 tens digit. The hours pair counts 00 to 23. While the hours tens digit is 0 or 1, the hours units digit wraps after 9. While the tens digit is 2, it wraps after 3, and the tens digit returns to 0 in the same cycle. A test input turns every clock cycle into a tick, so a whole day can be swept in 86400 cycles. The asynchronous active-low reset is synchronised internally before it is released.

Top module: `tod_clock_core`

## Requirements
- R1: While reset is low, all six digits read 0 and the tick output is low (with the test input low).
- R2: With the test input low, the tick output is high for exactly one cycle in every 32768 cycles. The first tick appears 32769 cycles after the reset input rises (two cycles of reset synchronisation plus 32767 counts).
- R3: While the test input is high, the tick output is high in every cycle, and the time advances by one second on every clock edge.
- R4: The seconds units digit advances by 1 on each tick and goes from 9 back to 0.
- R5: The seconds tens digit counts 0 to 5. It advances only in the cycle in which the seconds units digit wraps from 9 to 0, and it returns from 5 to 0.
- R6: The minutes units digit (0 to 9) and the minutes tens digit (0 to 5) follow the same rules as the seconds pair. The minutes pair advances only when the seconds pair wraps from 59 to 00.
- R7: The hours units digit counts 0 to 9 while the hours tens digit is below 2, and 0 to 3 while it is 2. The hours value never exceeds 23.
- R8: On the tick taken at 23:59:59, all six digits become 00:00:00 on the same clock edge.
- R9: In a cycle without a tick, no digit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, nominally 32768 Hz |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_bypass_i | input | 1 | Test input: when high, every cycle is a one-second tick |
| tick_o | output | 1 | One-second tick, high for one cycle |
| sec_units_o | output | 4 | Seconds units digit, BCD 0-9 |
| sec_tens_o | output | 4 | Seconds tens digit, BCD 0-5 |
| min_units_o | output | 4 | Minutes units digit, BCD 0-9 |
| min_tens_o | output | 4 | Minutes tens digit, BCD 0-5 |
| hr_units_o | output | 4 | Hours units digit, BCD 0-9 (0-3 when tens is 2) |
| hr_tens_o | output | 4 | Hours tens digit, BCD 0-2 |

## Verification
The tick output is read straight from the prescaler register. It is therefore visible in the same cycle in which the prescaler reaches its last count, and the digits change on the next clock edge. The test input reaches tick_o without any register in between, and the time then moves at the following edge. The bench drives every input at a falling edge and reads every output at the next falling edge. It compares the digits one cycle after each tick against a seconds count that it converts arithmetically into six digits. It also expects the first prescaled tick exactly 32769 cycles after reset release, and the second exactly 32768 cycles later. The bypassed sweep covers all 86400 seconds of a day and finishes with the midnight rollover.

// File: rtl/tod_pkg.sv
package tod_pkg;

  localparam int unsigned DIGIT_W    = 4;
  localparam int unsigned NUM_DIGITS = 6;

  typedef logic [DIGIT_W-1:0] bcd_t;

  // Highest value each digit can hold, lowest digit first:
  // sec units, sec tens, min units, min tens, hr units, hr tens.
  function automatic int unsigned digit_max(input int unsigned idx);
    case (idx)
      0, 2, 4: digit_max = 9;
      1, 3:    digit_max = 5;
      default: digit_max = 2;
    endcase
  endfunction

endpackage

// File: rtl/tod_reset_sync.sv
module tod_reset_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_no = sync_q;

endmodule

// File: rtl/tod_prescaler.sv
module tod_prescaler #(
  parameter int unsigned DIV = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bypass_i,
  output logic tick_o
);

  localparam int unsigned CW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          at_last;

  assign at_last = (cnt_q == LAST);

  always_comb begin
    if (at_last) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign tick_o = bypass_i | at_last;

  AST_PRESC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R2
  AST_PRESC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == LAST) |=> (cnt_q == '0)); // R2
  AST_PRESC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != LAST) |=> (cnt_q == CW'($past(cnt_q) + CW'(1)))); // R2

endmodule

// File: rtl/tod_digit.sv
module tod_digit
  import tod_pkg::*;
#(
  parameter int unsigned MAXV = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  bcd_t lim_i,
  output bcd_t q_o,
  output logic wrap_o
);

  bcd_t q_q;
  bcd_t q_d;
  logic at_lim;

  assign at_lim = (q_q == lim_i);

  always_comb begin
    q_d = q_q;
    if (en_i) begin
      if (at_lim) begin
        q_d = '0;
      end else begin
        q_d = q_q + bcd_t'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= '0;
    end else begin
      q_q <= q_d;
    end
  end

  assign q_o    = q_q;
  assign wrap_o = en_i & at_lim;

  AST_DIGIT_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_q <= bcd_t'(MAXV)); // R7
  AST_DIGIT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && q_q == lim_i) |=> (q_q == '0)); // R4
  AST_DIGIT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && q_q != lim_i) |=> (q_q == bcd_t'($past(q_q) + bcd_t'(1)))); // R4
  AST_DIGIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(q_q)); // R9

endmodule

// File: rtl/tod_clock_core.sv
module tod_clock_core
  import tod_pkg::*;
#(
  parameter int unsigned PRESCALE = 32768
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_bypass_i,
  output logic       tick_o,
  output logic [3:0] sec_units_o,
  output logic [3:0] sec_tens_o,
  output logic [3:0] min_units_o,
  output logic [3:0] min_tens_o,
  output logic [3:0] hr_units_o,
  output logic [3:0] hr_tens_o
);

  logic rst_sync_n;
  logic sec_tick;
  bcd_t digit [NUM_DIGITS];
  logic [NUM_DIGITS:0] carry;
  bcd_t hr_units_lim;

  tod_reset_sync u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  tod_prescaler #(
    .DIV (PRESCALE)
  ) u_prescaler (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .bypass_i (tick_bypass_i),
    .tick_o   (sec_tick)
  );

  assign carry[0] = sec_tick;

  // Hours units wrap after 3 once the tens digit shows 2.
  assign hr_units_lim = (digit[5] == bcd_t'(2)) ? bcd_t'(3) : bcd_t'(9);

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
    localparam int unsigned MAXV = digit_max(i);
    bcd_t lim;
    if (i == 4) begin : g_hr_units
      assign lim = hr_units_lim;
    end else begin : g_fixed
      assign lim = bcd_t'(MAXV);
    end
    tod_digit #(
      .MAXV (MAXV)
    ) u_digit (
      .clk_i  (clk_i),
      .rst_ni (rst_sync_n),
      .en_i   (carry[i]),
      .lim_i  (lim),
      .q_o    (digit[i]),
      .wrap_o (carry[i+1])
    );
  end

  assign tick_o      = sec_tick;
  assign sec_units_o = digit[0];
  assign sec_tens_o  = digit[1];
  assign min_units_o = digit[2];
  assign min_tens_o  = digit[3];
  assign hr_units_o  = digit[4];
  assign hr_tens_o   = digit[5];

  AST_HOUR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !(hr_tens_o == 4'd2 && hr_units_o > 4'd3)); // R7
  AST_DAY_ROLL: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    carry[NUM_DIGITS] |=> (sec_units_o == 4'd0 && sec_tens_o == 4'd0 &&
                           min_units_o == 4'd0 && min_tens_o == 4'd0 &&
                           hr_units_o == 4'd0 && hr_tens_o == 4'd0)); // R8
  AST_SEC_TENS_ADV: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (sec_tick && sec_units_o != 4'd9) |=> $stable(sec_tens_o)); // R5
  AST_BYPASS_ADV: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    tick_bypass_i |=> (sec_units_o != $past(sec_units_o))); // R3
  AST_MIN_ADV: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !(sec_tick && sec_units_o == 4'd9 && sec_tens_o == 4'd5) |=> $stable(min_units_o)); // R6

endmodule

// File: tb/tod_clock_core_tb.sv
module tod_clock_core_tb;

  localparam int unsigned DIV      = 32768;
  localparam int unsigned DAY      = 86400;
  localparam int unsigned WATCHDOG = 190000;

  logic       clk;
  logic       rst_n;
  logic       bypass;
  logic       tick;
  logic [3:0] su, st, mu, mt, hu, ht;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  tod_clock_core #(.PRESCALE(DIV)) u_dut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .tick_bypass_i (bypass),
    .tick_o        (tick),
    .sec_units_o   (su),
    .sec_tens_o    (st),
    .min_units_o   (mu),
    .min_tens_o    (mt),
    .hr_units_o    (hu),
    .hr_tens_o     (ht)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles >= WATCHDOG && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected below %0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d, expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  // Compare all six digits against a seconds-of-day count.
  task automatic chk_time(input int n, input string roll_tag);
    int s, m, h;
    s = n % 60;
    m = (n / 60) % 60;
    h = (n / 3600) % 24;
    chk_eq({roll_tag, "R4 sec units"}, int'(su), s % 10);
    chk_eq({roll_tag, "R5 sec tens"},  int'(st), s / 10);
    chk_eq({roll_tag, "R6 min units"}, int'(mu), m % 10);
    chk_eq({roll_tag, "R6 min tens"},  int'(mt), m / 10);
    chk_eq({roll_tag, "R7 hr units"},  int'(hu), h % 10);
    chk_eq({roll_tag, "R7 hr tens"},   int'(ht), h / 10);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n  = 1'b0;
    bypass = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk_time(0, "R1 ");
    chk_eq("R1 tick in reset", int'(tick), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    int k;
    int first_at;
    rst_n  = 1'b0;
    bypass = 1'b0;

    // Prescaled tick timing.
    do_reset();
    first_at = -1;
    for (k = 1; k <= DIV + 8; k++) begin
      @(negedge clk);
      if (k == DIV) chk_time(0, "R9 ");
      if (tick) begin
        first_at = k;
        break;
      end
    end
    chk_eq("R2 first tick cycle", first_at, DIV + 1);
    @(negedge clk);
    chk_eq("R2 tick one cycle", int'(tick), 0);
    chk_time(1, "");
    first_at = -1;
    for (k = 2; k <= DIV + 8; k++) begin
      @(negedge clk);
      if (tick) begin
        first_at = k;
        break;
      end
      if (int'(su) != 1) chk_eq("R9 hold between ticks", int'(su), 1);
    end
    chk_eq("R2 tick period", first_at, DIV);
    @(negedge clk);
    chk_time(2, "");

    // Full-day sweep with every cycle a tick.
    do_reset();
    for (int j = 0; j < 3; j++) @(negedge clk);
    chk_time(0, "R9 ");
    bypass = 1'b1;
    #1;
    chk_eq("R3 tick follows bypass", int'(tick), 1);
    for (int n = 1; n <= DAY; n++) begin
      @(negedge clk);
      if (n == DAY - 1) chk_time(n, "R8 pre ");
      else if (n == DAY) chk_time(0, "R8 ");
      else chk_time(n, "R3 ");
      if (!tick) chk_eq("R3 tick every cycle", int'(tick), 1);
    end
    for (int n = 1; n <= 5; n++) begin
      @(negedge clk);
      chk_time(n, "R3 ");
    end
    bypass = 1'b0;
    #1;
    chk_eq("R3 tick drops", int'(tick), 0);
    for (int j = 0; j < 5; j++) begin
      @(negedge clk);
      chk_time(5, "R9 ");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule